// File: doc/BRIEF.md
# Phase Detector Readout Averager

This block takes the per-cycle phase-error samples of two phase detectors, one belonging to a monitor loop and one to an auxiliary loop. It picks one of the two streams and smooths it with a first-order low-pass filter. The filter's time constant follows a one-bit loop-bandwidth setting: the wide setting halves the time constant, which gives the doubled smoothing bandwidth used with the fastest loop. The smoothed value is rounded and clamped to a signed 16-bit word, where one count stands for roughly 0.7 degrees. Software reads it as two bytes through a small read port.

Software reads the low byte first. That read also captures the high byte of the same value, so the two bytes always belong together. The filter keeps running across a source switch. After the switch the new source's phase offset shows up in the readback within a few time constants, before the loop has pulled it back. A measurement-mode input tells the block that the auxiliary detector is comparing two inputs with its feedback path opened. In that mode the output-valid flag is held low.

Top module: `phase_readout_avg`

## Requirements
- R1: While reset is asserted and on the first edge after it, `rd_data_o` is 0 and `out_valid_o` is 0. The filter state and the captured high byte are 0.
- R2: With `src_aux_i` = 0 the filter takes `mon_phase_i` qualified by `mon_valid_i`. With `src_aux_i` = 1 it takes `aux_phase_i` qualified by `aux_valid_i`. The stream that is not selected has no effect.
- R3: On an edge where the selected valid is low, the filter state does not change.
- R4: On an edge with an accepted sample x (18-bit signed), the state y (8 fraction bits) becomes y + floor((x*256 - y) / 2^k). Here k = 6 when `wide_bw_i` = 0 and k = 5 when `wide_bw_i` = 1.
- R5: The reported value is floor((y + 128) / 256), clamped to the range -32768 to 32767. It never wraps.
- R6: A read is requested by `rd_en_i` at an edge, and `rd_data_o` shows the result after that edge. `rd_addr_i` = 0 returns bits 7:0 of the reported value and captures bits 15:8 of that same value. `rd_addr_i` = 1 returns the captured byte.
- R7: The captured high byte changes only on a low-byte read, whatever the filter does in the meantime.
- R8: After each edge, `out_valid_o` is 1 exactly when at least one sample has been accepted since reset and `open_loop_i` was 0 at that edge.
- R9: On an edge with `rd_en_i` = 0, `rd_data_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_phase_i | input | 18 | Monitor-loop phase sample, signed |
| mon_valid_i | input | 1 | Monitor sample present this cycle |
| aux_phase_i | input | 18 | Auxiliary-loop phase sample, signed |
| aux_valid_i | input | 1 | Auxiliary sample present this cycle |
| src_aux_i | input | 1 | 1 selects the auxiliary detector |
| wide_bw_i | input | 1 | 1 selects the halved time constant |
| open_loop_i | input | 1 | Open-loop input-to-input measurement active |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 1 | 0 low byte (captures high), 1 high byte |
| rd_data_o | output | 8 | Read data, one cycle after the request |
| out_valid_o | output | 1 | Reported value is meaningful |

## Verification
The assertions assume that every input is a known value at each clock edge outside reset. They also assume that the detectors deliver samples in the signed 18-bit range. Nothing is assumed about how reads are ordered. The stimulus changes inputs only on the falling edge, and it draws samples within 18 bits, including both extremes, so that the clamp is reached in both directions. High-byte reads come in at arbitrary distances from the preceding low-byte read.

// File: rtl/phase_avg_pkg.sv
package phase_avg_pkg;
    localparam int BYTE_W = 8;
    typedef enum logic {
        RD_LOW  = 1'b0,
        RD_HIGH = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/phase_iir.sv
module phase_iir #(
    parameter int IN_W   = 18,
    parameter int FRAC   = 8,
    parameter int SH_NAR = 6,
    parameter int SH_WID = 5,
    localparam int ACC_W = IN_W + FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  smp_i,
    input  logic                    smp_valid_i,
    input  logic                    wide_i,
    output logic signed [ACC_W-1:0] acc_o
);
    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;
    logic signed [ACC_W-1:0] tgt;
    logic signed [ACC_W:0]   diff;
    logic signed [ACC_W:0]   step;

    always_comb begin
        st_d = st_q;
        tgt  = $signed({smp_i, {FRAC{1'b0}}});
        diff = $signed({tgt[ACC_W-1], tgt}) - $signed({st_q.acc[ACC_W-1], st_q.acc});
        step = wide_i ? (diff >>> SH_WID) : (diff >>> SH_NAR);
        if (smp_valid_i) begin
            st_d.acc = st_q.acc + step[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.acc;

    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_i |=> $stable(acc_o)); // R3
    AST_ACC_TOWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && tgt >= acc_o) |=> acc_o >= $past(acc_o)); // R4
    AST_ACC_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && tgt <= acc_o) |=> acc_o <= $past(acc_o)); // R4
endmodule

// File: rtl/phase_report.sv
module phase_report #(
    parameter int ACC_W = 26,
    parameter int FRAC  = 8,
    parameter int OUT_W = 16
) (
    input  logic signed [ACC_W-1:0] acc_i,
    output logic signed [OUT_W-1:0] rep_o
);
    localparam logic signed [ACC_W:0] HALF   = (ACC_W+1)'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W:0] MAXV   = (ACC_W+1)'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W:0] MINV   = -MAXV - 1;

    logic signed [ACC_W:0] rnd;

    always_comb begin
        rnd = ($signed({acc_i[ACC_W-1], acc_i}) + HALF) >>> FRAC;
        if (rnd > MAXV)      rep_o = MAXV[OUT_W-1:0];
        else if (rnd < MINV) rep_o = MINV[OUT_W-1:0];
        else                 rep_o = rnd[OUT_W-1:0];
    end
endmodule

// File: rtl/phase_rdport.sv
module phase_rdport
    import phase_avg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en_i,
    input  logic                rd_addr_i,
    input  logic [2*BYTE_W-1:0] value_i,
    output logic [BYTE_W-1:0]   rd_data_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] hold;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en_i) begin
            if (rd_sel_e'(rd_addr_i) == RD_LOW) begin
                st_d.data = value_i[BYTE_W-1:0];
                st_d.hold = value_i[2*BYTE_W-1:BYTE_W];
            end else begin
                st_d.data = st_q.hold;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.data;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && rd_addr_i == RD_LOW) |=> $stable(st_q.hold)); // R7
    AST_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o)); // R9
endmodule

// File: rtl/phase_readout_avg.sv
module phase_readout_avg
    import phase_avg_pkg::*;
#(
    parameter int IN_W   = 18,
    parameter int FRAC   = 8,
    parameter int SH_NAR = 6,
    parameter int SH_WID = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IN_W-1:0]        mon_phase_i,
    input  logic                   mon_valid_i,
    input  logic [IN_W-1:0]        aux_phase_i,
    input  logic                   aux_valid_i,
    input  logic                   src_aux_i,
    input  logic                   wide_bw_i,
    input  logic                   open_loop_i,
    input  logic                   rd_en_i,
    input  logic                   rd_addr_i,
    output logic [BYTE_W-1:0]      rd_data_o,
    output logic                   out_valid_o
);
    localparam int ACC_W = IN_W + FRAC;
    localparam int OUT_W = 2 * BYTE_W;

    typedef struct packed {
        logic seen;
        logic valid;
    } st_t;

    st_t st_d, st_q;
    logic signed [IN_W-1:0]  smp;
    logic                    smp_valid;
    logic signed [ACC_W-1:0] acc;
    logic signed [OUT_W-1:0] rep;

    always_comb begin
        smp       = src_aux_i ? $signed(aux_phase_i) : $signed(mon_phase_i);
        smp_valid = src_aux_i ? aux_valid_i : mon_valid_i;
        st_d      = st_q;
        st_d.seen  = st_q.seen | smp_valid;
        st_d.valid = (st_q.seen | smp_valid) & ~open_loop_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    phase_iir #(
        .IN_W(IN_W), .FRAC(FRAC), .SH_NAR(SH_NAR), .SH_WID(SH_WID)
    ) u_iir (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .smp_valid_i(smp_valid),
        .wide_i(wide_bw_i), .acc_o(acc)
    );

    phase_report #(
        .ACC_W(ACC_W), .FRAC(FRAC), .OUT_W(OUT_W)
    ) u_rep (
        .acc_i(acc), .rep_o(rep)
    );

    phase_rdport u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .value_i(rep), .rd_data_o(rd_data_o)
    );

    assign out_valid_o = st_q.valid;

    AST_VALID_OPEN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        open_loop_i |=> !out_valid_o); // R8
    AST_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == RD_LOW) |=> rd_data_o == $past(rep[BYTE_W-1:0])); // R6
    AST_VALID_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.seen && !smp_valid) |=> !out_valid_o); // R8
endmodule

// File: tb/tb_phase_readout_avg.sv
module tb_phase_readout_avg;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [17:0] mon_phase = '0, aux_phase = '0;
    logic mon_valid = 1'b0, aux_valid = 1'b0, src_aux = 1'b0, wide_bw = 1'b0;
    logic open_loop = 1'b0, rd_en = 1'b0, rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic out_valid;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    longint m_acc;
    int m_hold, m_rd, m_valid, m_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_readout_avg dut (
        .clk(clk), .rst_n(rst_n),
        .mon_phase_i(mon_phase), .mon_valid_i(mon_valid),
        .aux_phase_i(aux_phase), .aux_valid_i(aux_valid),
        .src_aux_i(src_aux), .wide_bw_i(wide_bw), .open_loop_i(open_loop),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .out_valid_o(out_valid)
    );

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, evaluated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_hold = 0; m_rd = 0; m_valid = 0; m_seen = 0;
        end else begin
            longint r, x, d;
            int rep;
            bit sv;
            r = (m_acc + 128) >>> 8;
            if (r > 32767) r = 32767;
            if (r < -32768) r = -32768;
            rep = int'(r) & 16'hFFFF;
            if (rd_en) begin
                if (rd_addr == 1'b0) begin
                    m_rd = rep & 8'hFF;
                    m_hold = (rep >> 8) & 8'hFF;
                end else begin
                    m_rd = m_hold;
                end
            end
            sv = src_aux ? aux_valid : mon_valid;
            x = src_aux ? longint'($signed(aux_phase)) : longint'($signed(mon_phase));
            if (sv) begin
                d = x * 256 - m_acc;
                m_acc = m_acc + (d >>> (wide_bw ? 5 : 6));
            end
            m_valid = ((m_seen != 0) || sv) && !open_loop;
            if (sv) m_seen = 1;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, rd_data, m_rd);
            check("R8", out_valid, m_valid);
        end
    end

    function automatic logic [17:0] rnd18(int lim);
        int v;
        v = int'($urandom_range(2 * lim)) - lim;
        return v[17:0];
    endfunction

    task automatic run(int n, int rd_pct, bit rnd_data, int vpct);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_en   = ($urandom_range(99) < rd_pct);
            rd_addr = $urandom_range(1);
            if (rnd_data) begin
                mon_phase = rnd18(131071);
                aux_phase = rnd18(131071);
            end
            if (vpct >= 0) begin
                mon_valid = ($urandom_range(99) < vpct);
                aux_valid = ($urandom_range(99) < vpct);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1", rd_data, 0);
        check("R1", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", rd_data, 0);
        check("R1", out_valid, 0);

        // R4 narrow, monitor selected, auxiliary noise ignored (R2)
        cur_req = "R4";
        mon_phase = 18'd1000; mon_valid = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            aux_phase = rnd18(131071); aux_valid = $urandom_range(1);
            rd_en = ($urandom_range(3) == 0); rd_addr = $urandom_range(1);
        end
        // R4 wide setting
        wide_bw = 1'b1; mon_phase = -18'sd3000;
        run(150, 30, 1'b0, -1);

        // R2 auxiliary source, random data and gating
        cur_req = "R2";
        src_aux = 1'b1;
        run(300, 30, 1'b1, 70);

        // R3 selected valid low, data moving
        cur_req = "R3";
        aux_valid = 1'b0; mon_valid = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            aux_phase = rnd18(131071); mon_phase = rnd18(131071);
            rd_en = ($urandom_range(1) == 0); rd_addr = $urandom_range(1);
        end

        // R5 clamp at both ends
        cur_req = "R5";
        aux_valid = 1'b1; aux_phase = 18'sd131071;
        run(500, 25, 1'b0, -1);
        aux_phase = -18'sd131072;
        run(500, 25, 1'b0, -1);

        // R7 coherence: low read, data moves, high read later
        cur_req = "R7";
        wide_bw = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); rd_en = 1'b1; rd_addr = 1'b0; aux_phase = rnd18(131071);
            @(negedge clk); rd_en = 1'b0;
            for (int j = 0; j < k * 7; j++) begin
                @(negedge clk); aux_phase = rnd18(131071);
                rd_en = ($urandom_range(3) == 0); rd_addr = 1'b1;
            end
            @(negedge clk); rd_en = 1'b1; rd_addr = 1'b1;
            @(negedge clk); rd_en = 1'b0;
        end

        // R8 open-loop measurement toggling
        cur_req = "R8";
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            open_loop = ($urandom_range(2) == 0);
            rd_en = ($urandom_range(3) == 0); rd_addr = $urandom_range(1);
            aux_phase = rnd18(80000);
        end
        open_loop = 1'b0;

        // R9 no reads: data must hold
        cur_req = "R9";
        run(100, 0, 1'b1, 80);

        // R6 mixed traffic, all settings random
        cur_req = "R6";
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            src_aux = ($urandom_range(19) == 0) ? ~src_aux : src_aux;
            wide_bw = ($urandom_range(29) == 0) ? ~wide_bw : wide_bw;
            open_loop = ($urandom_range(9) == 0);
            mon_phase = rnd18(131071); aux_phase = rnd18(131071);
            mon_valid = $urandom_range(1); aux_valid = $urandom_range(1);
            rd_en = $urandom_range(1); rd_addr = $urandom_range(1);
        end
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule